// File: doc/BRIEF.md
# Integer Execution Unit with Shifter

This block is the purely combinational integer execution stage of a three-operand load/store processor core. Each evaluation takes two 32-bit operands, a 5-bit immediate shift count and a 4-bit operation code, and produces one 32-bit result together with an equality flag for conditional branches. The supported operations are wrapping add and subtract, bitwise AND, OR and NOR, a signed less-than compare that yields 0 or 1, logical shifts in both directions by the immediate count, placement of a 16-bit constant in the upper half of a word, and the base-plus-offset sum used to address loads and stores.

The unit has no state. Operand selection, immediate extension of everything except the address offset, and decoding of instructions into operation codes belong to the surrounding pipeline. Because the block holds no data, it has no flow control: the result is valid whenever the inputs are, within the same cycle, and the pipeline register that consumes it supplies any stalling.

Top module: `int_exec_alu`

## Requirements
- R1: Operation code 0 returns opnd_a + opnd_b modulo 2^32; a carry out of bit 31 or a signed overflow is dropped without any indication.
- R2: Operation code 1 returns opnd_a - opnd_b modulo 2^32, wrapping silently.
- R3: Operation codes 2, 3 and 4 return opnd_a AND opnd_b, opnd_a OR opnd_b, and the bitwise inverse of (opnd_a OR opnd_b) respectively.
- R4: Operation code 5 returns 1 when opnd_a is less than opnd_b with both read as two's complement numbers, and 0 otherwise; bits 31:1 are always zero.
- R5: Operation codes 6 and 7 shift opnd_a left and right respectively by the count on shamt (0 to 31), filling vacated positions with zeros; shamt has no effect on any other operation code.
- R6: Operation code 8 returns opnd_b[15:0] in bits 31:16 and zeros in bits 15:0; opnd_a has no effect on it.
- R7: The zero output is 1 exactly when opnd_a - opnd_b equals zero (the operands are equal), whatever the operation code.
- R8: Operation codes 10 through 15 return a result of zero.
- R9: Operation code 9 returns opnd_a plus the sign extension of opnd_b[15:0] to 32 bits, modulo 2^32, forming a load/store address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code, encodings listed in the requirements |
| opnd_a | input | 32 | First source operand; shifted operand; address base |
| opnd_b | input | 32 | Second source operand; low half is the constant for upper placement and the address offset |
| shamt | input | 5 | Immediate shift count for the two shift operations |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the two operands subtract to zero |

## Verification
With no storage, any fault is a wrong mapping from inputs to outputs and shows on result or zero in the very cycle the offending operands are applied; nothing can hide for later cycles. The faults that matter most live at bit boundaries: a missing carry into bit 31, a signed compare that reads the sign bit as magnitude, a shift stage wired to the wrong distance, or an offset extended with zeros instead of its sign. Operands of zero, all ones, the most negative and the most positive value, crossed with every operation code and the extreme shift counts, make each of those faults change an output.

// File: rtl/int_exec_alu_pkg.sv
package int_exec_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_HIGH = 4'd8,
    OP_ADDR = 4'd9
  } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              do_sub,
  output logic [DATA_W-1:0] sum
);

  logic [DATA_W-1:0] rhs_eff;

  always_comb begin
    rhs_eff = rhs ^ {DATA_W{do_sub}};
    sum     = lhs + rhs_eff + {{(DATA_W-1){1'b0}}, do_sub};
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SHAMT_W  = 5,
  parameter bit          DIR_LEFT = 1'b1
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amount,
  output logic [DATA_W-1:0]  dout
);

  logic [DATA_W-1:0] stage [SHAMT_W+1];

  assign stage[0] = din;

  for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
    localparam int unsigned DIST = 1 << i;
    if (DIR_LEFT) begin : g_left
      assign stage[i+1] = amount[i] ? {stage[i][DATA_W-1-DIST:0], {DIST{1'b0}}} : stage[i];
    end else begin : g_right
      assign stage[i+1] = amount[i] ? {{DIST{1'b0}}, stage[i][DATA_W-1:DIST]} : stage[i];
    end
  end

  assign dout = stage[SHAMT_W];

  always_comb begin
    if (amount == '0) begin
      AST_SHIFT_IDENT: assert (dout == din); // R5
    end
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] and_out,
  output logic [DATA_W-1:0] or_out,
  output logic [DATA_W-1:0] nor_out
);

  always_comb begin
    and_out = lhs & rhs;
    or_out  = lhs | rhs;
    nor_out = ~or_out;
  end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_exec_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMM_W   = 16,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [3:0]         op_sel,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result,
  output logic               zero
);

  localparam int unsigned MSB    = DATA_W - 1;
  localparam int unsigned LOW_W  = DATA_W - IMM_W;

  logic [DATA_W-1:0] offset_sx;
  logic [DATA_W-1:0] sum_rhs;
  logic [DATA_W-1:0] sum_out;
  logic [DATA_W-1:0] diff_out;
  logic [DATA_W-1:0] shl_out;
  logic [DATA_W-1:0] shr_out;
  logic [DATA_W-1:0] and_out;
  logic [DATA_W-1:0] or_out;
  logic [DATA_W-1:0] nor_out;
  logic [DATA_W-1:0] high_out;
  logic              less;

  // Address offset: low immediate bits, sign bit replicated upward.
  assign offset_sx = {{LOW_W{opnd_b[IMM_W-1]}}, opnd_b[IMM_W-1:0]};
  assign sum_rhs   = (op_sel == OP_ADDR) ? offset_sx : opnd_b;
  assign high_out  = {opnd_b[IMM_W-1:0], {LOW_W{1'b0}}};

  // Adder for add and address generation.
  alu_addsub #(.DATA_W(DATA_W)) u_sum (
    .lhs    (opnd_a),
    .rhs    (sum_rhs),
    .do_sub (1'b0),
    .sum    (sum_out)
  );

  // Dedicated subtractor: feeds sub, compare and the branch flag.
  alu_addsub #(.DATA_W(DATA_W)) u_cmp (
    .lhs    (opnd_a),
    .rhs    (opnd_b),
    .do_sub (1'b1),
    .sum    (diff_out)
  );

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .DIR_LEFT(1'b1)) u_shl (
    .din    (opnd_a),
    .amount (shamt),
    .dout   (shl_out)
  );

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .DIR_LEFT(1'b0)) u_shr (
    .din    (opnd_a),
    .amount (shamt),
    .dout   (shr_out)
  );

  alu_bitwise #(.DATA_W(DATA_W)) u_logic (
    .lhs     (opnd_a),
    .rhs     (opnd_b),
    .and_out (and_out),
    .or_out  (or_out),
    .nor_out (nor_out)
  );

  // Signed compare: differing signs decide directly, else the difference sign.
  assign less = (opnd_a[MSB] ^ opnd_b[MSB]) ? opnd_a[MSB] : diff_out[MSB];
  assign zero = (diff_out == '0);

  always_comb begin
    case (op_sel)
      OP_ADD:  result = sum_out;
      OP_SUB:  result = diff_out;
      OP_AND:  result = and_out;
      OP_OR:   result = or_out;
      OP_NOR:  result = nor_out;
      OP_SLT:  result = {{(DATA_W-1){1'b0}}, less};
      OP_SHL:  result = shl_out;
      OP_SHR:  result = shr_out;
      OP_HIGH: result = high_out;
      OP_ADDR: result = sum_out;
      default: result = '0;
    endcase
  end

  always_comb begin
    if (op_sel == OP_NOR) begin
      AST_NOR_DISJOINT: assert (((result & (opnd_a | opnd_b)) == '0) && ((result | opnd_a | opnd_b) == '1)); // R3
    end
    if (op_sel == OP_SLT) begin
      AST_SLT_BOOL: assert (result[DATA_W-1:1] == '0); // R4
    end
    if (op_sel == OP_SHL) begin
      AST_SHL_ZFILL: assert ((result & ~({DATA_W{1'b1}} << shamt)) == '0); // R5
    end
    if (op_sel == OP_HIGH) begin
      AST_HIGH_LOWZERO: assert (result[LOW_W-1:0] == '0); // R6
    end
    if (op_sel > 4'd9) begin
      AST_UNUSED_ZERO: assert (result == '0); // R8
    end
    AST_ZERO_EQUAL: assert (zero == (opnd_a == opnd_b)); // R7
  end

endmodule

// File: tb/int_exec_alu_test.sv
`timescale 1ns/1ps
module int_exec_alu_test;

  typedef struct {
    logic [31:0] exp_res;
    logic        exp_zero;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  sh;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  exp_item_t sb_q[$];

  always #10 clk = ~clk;

  int_exec_alu uut (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .shamt  (shamt),
    .result (result),
    .zero   (zero)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R9";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                       input logic [31:0] b, input logic [4:0] sh);
    longint sa, sb_v;
    sa   = longint'($signed(a));
    sb_v = longint'($signed(b));
    case (op)
      4'd0: return 32'((64'(a) + 64'(b)) % 64'h1_0000_0000);
      4'd1: return 32'((64'(a) + 64'h1_0000_0000 - 64'(b)) % 64'h1_0000_0000);
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return ~(a | b);
      4'd5: return (sa < sb_v) ? 32'd1 : 32'd0;
      4'd6: return 32'(64'(a) << sh);
      4'd7: return a >> sh;
      4'd8: return {b[15:0], 16'h0000};
      4'd9: return a + {{16{b[15]}}, b[15:0]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] sh);
    exp_item_t it;
    @(negedge clk);
    op_sel = op;
    opnd_a = a;
    opnd_b = b;
    shamt  = sh;
    it.exp_res  = model(op, a, b, sh);
    it.exp_zero = (a == b);
    it.op = op; it.a = a; it.b = b; it.sh = sh;
    sb_q.push_back(it);
  endtask

  // Monitor: outputs settle half a cycle after the driver's negedge.
  always @(posedge clk) begin
    if (sb_q.size() != 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (result !== it.exp_res) begin
        errors++;
        $display("FAIL %s op=%0d a=%h b=%h sh=%0d result actual=%h expected=%h",
                 req_of(it.op), it.op, it.a, it.b, it.sh, result, it.exp_res);
      end
      checks++;
      if (zero !== it.exp_zero) begin
        errors++;
        $display("FAIL R7 op=%0d a=%h b=%h zero actual=%b expected=%b",
                 it.op, it.a, it.b, zero, it.exp_zero);
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d cycles expected=completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [5];
    corners[0] = 32'h0000_0000;
    corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000;
    corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h0000_0001;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 wrap, R2 wrap, R4 extremes, R9 negative offset: directed cases
    drive(4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
    drive(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);
    drive(4'd1, 32'h0000_0000, 32'h0000_0001, 5'd0);
    drive(4'd1, 32'h8000_0000, 32'h0000_0001, 5'd0);
    drive(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    drive(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    drive(4'd5, 32'hFFFF_FFFF, 32'h0000_0000, 5'd0);
    drive(4'd9, 32'h0000_1000, 32'h1234_FFFC, 5'd0);
    drive(4'd9, 32'h0000_1000, 32'hFFFF_7FFF, 5'd0);
    drive(4'd8, 32'hDEAD_BEEF, 32'h5555_AAAA, 5'd3);
    drive(4'd6, 32'h8000_0001, 32'h0, 5'd31);
    drive(4'd7, 32'h8000_0001, 32'h0, 5'd31);

    // Corner operands across every code and extreme shift counts (R1..R9)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int s = 0; s < 3; s++)
            drive(4'(op), corners[i], corners[j], (s == 0) ? 5'd0 : (s == 1) ? 5'd1 : 5'd31);

    // Random operands, random codes
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      ra = $urandom;
      rb = (k % 7 == 0) ? ra : $urandom;
      drive(4'($urandom_range(15, 0)), ra, rb, 5'($urandom_range(31, 0)));
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule